// File: doc/BRIEF.md
# Target Address De-interleaver

This block turns a system physical address into a dense address local to one memory channel. The memory controller and the channel have already been chosen upstream, and the block receives the address with that channel number. It compares the address against eight programmable target ranges. In the first range that contains it, the block subtracts that range's offset for the requested channel. It then removes two interleave levels, one across sockets and one across channels, and returns the compacted address together with the socket and channel way counts of the range.

Each interleave level has a selectable granularity bit and a way count. A channel level of three ways needs a true divide by three, which a small bit-serial divider performs. Way counts that are powers of two complete with a plain shift in one cycle. When the channel level is three-way and the socket granularity bit lies above the channel granularity bit, the two levels are removed in the opposite order. Software programs the ranges through a simple register write port. Requests arrive and results leave on valid/ready handshakes, one request at a time.

Top module: `tad_deilv`

## Requirements
- R1: The block holds 8 entries. Entry i covers addresses from its base to its limit, both included. The base is base-register bits 31:12 shifted left by 26. The limit is wayness-register bits 31:12 shifted left by 26 with the low 26 bits all ones. When several entries cover an address, the lowest index wins.
- R2: An address outside every entry returns outErr=1, with outAddr, outSktWays and outChWays all zero.
- R3: For a hit, outSktWays equals 1 shifted left by wayness bits 11:10, and outChWays equals wayness bits 9:8 plus one (1, 2, 3 or 4).
- R4: A 2-bit granularity code selects the interleave bit: 0 gives 6, 1 gives 8, 2 gives 12, 3 gives 30. The socket code is base bits 5:4 and the channel code is base bits 7:6.
- R5: Each entry has one offset per channel (channels 0 to 3). The offset is bits 23:4 of the offset register shifted left by 26, and it is subtracted (modulo 2^46) from the address of the selected channel before any interleave is removed.
- R6: Removing one level with bit g, w ways and a low source L yields (((v >> g) / w) << g) | (L mod 2^g). Three ways uses a true division.
- R7: When the channel ways equal 3 and the socket bit is greater than the channel bit, the channel level is removed first and then the socket level, each taking its low bits from its own input value. Otherwise the socket level is removed first and then the channel level, both taking their low bits from the original request address.
- R8: inReady is high only while idle, and a request is accepted on a clock edge with inValid and inReady both high. outValid then stays high, with outAddr, outErr and the way outputs unchanged, until outReady is sampled high.
- R9: When neither level is three-way, outValid rises on the third clock edge after the accepting edge. For a miss, it rises on the first.
- R10: A configuration write uses cfgKind 0 for base, 1 for wayness, 2 for the per-channel offset (selected by cfgChan) and 3 for nothing, and cfgEntry selects the entry. A kind-3 write changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgKind | input | 2 | Register kind: 0 base, 1 wayness, 2 offset, 3 none |
| cfgEntry | input | 3 | Entry index |
| cfgChan | input | 2 | Channel for offset writes |
| cfgData | input | 32 | Write data |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | Request ready (idle) |
| inAddr | input | 46 | System address |
| inChan | input | 2 | Selected channel |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Result taken |
| outAddr | output | 46 | Channel-local address |
| outErr | output | 1 | No entry matched |
| outSktWays | output | 4 | Socket ways of the matched entry |
| outChWays | output | 3 | Channel ways of the matched entry |

## Verification
One entry is reprogrammed through every combination of socket code, channel code, socket way count and channel way count, 256 in all. Each combination is driven with two scattered addresses on rotating channels. The resulting addresses separate the shift path from the divide-by-three path and the two removal orders, and the rotating channels show that the right per-channel offset is used. Overlapping low entries show whether the lowest index wins. Addresses placed exactly on a base, exactly on a limit and one step outside a range confirm the inclusive bounds and the miss result. Timed requests on the shift path and on a miss pin down the latency.

// File: rtl/tad_pkg.sv
package tad_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_MATCH, S_L1GO, S_L1WAIT, S_L2GO, S_L2WAIT, S_DONE
  } tadState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // capture request
    logic doMatch;    // latch entry, subtract offset
    logic lvlGo;      // start an interleave level
    logic lvlSecond;  // level being worked is the second one
  } tadStrobe_t;

  function automatic logic [4:0] granBit(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd6;
      2'd1:    return 5'd8;
      2'd2:    return 5'd12;
      default: return 5'd30;
    endcase
  endfunction

endpackage

// File: rtl/tad_div3.sv
module tad_div3 #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     sh;
  logic [1:0]       rem;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       trial;
  logic             qBit;
  logic [1:0]       remNx;

  assign trial = {rem, sh[W-1]};
  assign qBit  = (trial >= 3'd3);
  assign remNx = qBit ? 2'(trial - 3'd3) : trial[1:0];
  assign done  = busy && (cnt == CNT_W'(W - 1));
  assign quot  = {sh[W-2:0], qBit};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sh <= '0; rem <= '0; cnt <= '0; busy <= 1'b0;
    end else if (start) begin
      sh <= dividend; rem <= '0; cnt <= '0; busy <= 1'b1;
    end else if (busy) begin
      sh  <= {sh[W-2:0], qBit};
      rem <= remNx;
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  p_rem_below3_r6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> rem != 2'd3);
  p_done_stops_r6: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> !busy);

endmodule

// File: rtl/tad_ctrl.sv
module tad_ctrl
  import tad_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  input  logic       hit,
  input  logic       lvlFast,
  input  logic       divDone,
  output logic       inReady,
  output logic       outValid,
  output tadStrobe_t strobe
);
  tadState_e state, stateNx;

  always_comb begin
    stateNx = state;
    strobe  = '0;
    case (state)
      S_IDLE: if (inValid) begin strobe.loadReq = 1'b1; stateNx = S_MATCH; end
      S_MATCH: begin
        strobe.doMatch = 1'b1;
        stateNx = hit ? S_L1GO : S_DONE;
      end
      S_L1GO: begin
        strobe.lvlGo = 1'b1;
        stateNx = lvlFast ? S_L2GO : S_L1WAIT;
      end
      S_L1WAIT: if (divDone) stateNx = S_L2GO;
      S_L2GO: begin
        strobe.lvlGo = 1'b1; strobe.lvlSecond = 1'b1;
        stateNx = lvlFast ? S_DONE : S_L2WAIT;
      end
      S_L2WAIT: begin
        strobe.lvlSecond = 1'b1;
        if (divDone) stateNx = S_DONE;
      end
      S_DONE: if (outReady) stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNx;
  end

  assign inReady  = (state == S_IDLE);
  assign outValid = (state == S_DONE);

  p_miss_skips_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MATCH && !hit) |=> outValid);
  p_wait_until_div_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_L1WAIT && !divDone) |=> state == S_L1WAIT);

endmodule

// File: rtl/tad_dpath.sv
module tad_dpath
  import tad_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter int N_ENT  = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [$clog2(N_ENT)-1:0] cfgEntry,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [31:0]       cfgData,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [CH_W-1:0]   inChan,
  input  tadStrobe_t        strobe,
  output logic              hit,
  output logic              lvlFast,
  output logic              divDone,
  output logic [ADDR_W-1:0] resAddr,
  output logic              resErr,
  output logic [3:0]        resSktWays,
  output logic [2:0]        resChWays
);
  localparam int LOW_W = 26;
  localparam int FLD_W = ADDR_W - LOW_W;
  localparam int IDX_W = $clog2(N_ENT);
  localparam int N_CH  = 1 << CH_W;

  logic [FLD_W-1:0] baseFld [N_ENT];
  logic [1:0]       skGc    [N_ENT];
  logic [1:0]       chGc    [N_ENT];
  logic [FLD_W-1:0] limFld  [N_ENT];
  logic [1:0]       skLog   [N_ENT];
  logic [1:0]       chF     [N_ENT];
  logic [FLD_W-1:0] offFld  [N_ENT][N_CH];
  logic             unusedCfgBits;
  assign unusedCfgBits = ^cfgData[3:0];

  // configuration registers, one generate slice per entry
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseFld[e] <= '0; skGc[e] <= '0; chGc[e] <= '0;
        limFld[e]  <= '0; skLog[e] <= '0; chF[e] <= '0;
        for (int c = 0; c < N_CH; c++) offFld[e][c] <= '0;
      end else if (cfgWe && cfgEntry == IDX_W'(e)) begin
        case (cfgKind)
          2'd0: begin
            baseFld[e] <= cfgData[12 +: FLD_W];
            chGc[e]    <= cfgData[7:6];
            skGc[e]    <= cfgData[5:4];
          end
          2'd1: begin
            limFld[e] <= cfgData[12 +: FLD_W];
            skLog[e]  <= cfgData[11:10];
            chF[e]    <= cfgData[9:8];
          end
          2'd2: offFld[e][cfgChan] <= cfgData[4 +: FLD_W];
          default: ;
        endcase
      end
    end
  end

  logic [ADDR_W-1:0] reqAddr, work;
  logic [CH_W-1:0]   reqChan;
  logic [IDX_W-1:0]  entIdx, matchIdx;
  logic              err;

  // lowest index wins: scan from the top so lower hits overwrite
  always_comb begin
    hit = 1'b0;
    matchIdx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if ({baseFld[i], {LOW_W{1'b0}}} <= reqAddr &&
          reqAddr <= {limFld[i], {LOW_W{1'b1}}}) begin
        hit = 1'b1;
        matchIdx = IDX_W'(i);
      end
    end
  end

  logic [4:0] skG, chG, g;
  logic       chFirst, lvlIsCh;
  logic [1:0] pw;
  logic [ADDR_W-1:0] lowSrc, lowMask, shifted, fastQ, divQ, fastRes, divRes;
  logic       divStart, divBusy;

  assign skG     = granBit(skGc[entIdx]);
  assign chG     = granBit(chGc[entIdx]);
  assign chFirst = (chF[entIdx] == 2'd2) && (skG > chG);
  assign lvlIsCh = strobe.lvlSecond ? !chFirst : chFirst;
  assign g       = lvlIsCh ? chG : skG;
  assign lowSrc  = chFirst ? work : reqAddr;
  assign lowMask = ~({ADDR_W{1'b1}} << g);
  assign pw      = lvlIsCh ? ((chF[entIdx] == 2'd3) ? 2'd2 :
                              (chF[entIdx] == 2'd1) ? 2'd1 : 2'd0)
                           : skLog[entIdx];
  assign lvlFast = !(lvlIsCh && chF[entIdx] == 2'd2);
  assign shifted = work >> g;
  assign fastQ   = shifted >> pw;
  assign fastRes = (fastQ << g) | (lowSrc & lowMask);
  assign divRes  = (divQ << g) | (lowSrc & lowMask);
  assign divStart = strobe.lvlGo && !lvlFast;

  tad_div3 #(.W(ADDR_W)) u_div (
    .clk(clk), .rstN(rstN), .start(divStart), .dividend(shifted),
    .busy(divBusy), .done(divDone), .quot(divQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqAddr <= '0; reqChan <= '0; entIdx <= '0; err <= 1'b0; work <= '0;
    end else begin
      if (strobe.loadReq) begin
        reqAddr <= inAddr;
        reqChan <= inChan;
      end
      if (strobe.doMatch) begin
        entIdx <= matchIdx;
        err    <= !hit;
        work   <= hit ? reqAddr - {offFld[matchIdx][reqChan], {LOW_W{1'b0}}} : '0;
      end else if (strobe.lvlGo && lvlFast) begin
        work <= fastRes;
      end else if (divDone) begin
        work <= divRes;
      end
    end
  end

  assign resAddr    = work;
  assign resErr     = err;
  assign resSktWays = err ? 4'd0 : (4'd1 << skLog[entIdx]);
  assign resChWays  = err ? 3'd0 : (3'(chF[entIdx]) + 3'd1);

  p_no_div_on_fast_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.lvlGo && lvlFast) |-> !divBusy);

endmodule

// File: rtl/tad_deilv.sv
module tad_deilv
  import tad_pkg::*;
#(
  parameter int ADDR_W = 46,
  parameter int N_ENT  = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgKind,
  input  logic [$clog2(N_ENT)-1:0] cfgEntry,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [31:0]       cfgData,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [CH_W-1:0]   inChan,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outErr,
  output logic [3:0]        outSktWays,
  output logic [2:0]        outChWays
);
  tadStrobe_t strobe;
  logic hit, lvlFast, divDone;

  tad_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .hit(hit), .lvlFast(lvlFast), .divDone(divDone),
    .inReady(inReady), .outValid(outValid), .strobe(strobe)
  );

  tad_dpath #(.ADDR_W(ADDR_W), .N_ENT(N_ENT), .CH_W(CH_W)) u_dpath (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgEntry(cfgEntry), .cfgChan(cfgChan), .cfgData(cfgData),
    .inAddr(inAddr), .inChan(inChan), .strobe(strobe),
    .hit(hit), .lvlFast(lvlFast), .divDone(divDone),
    .resAddr(outAddr), .resErr(outErr),
    .resSktWays(outSktWays), .resChWays(outChWays)
  );

  p_idle_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);
  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outAddr) &&
                                $stable(outErr) && $stable(outChWays));
  p_skt_pow2_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outErr) |-> $countones(outSktWays) == 1);

endmodule

// File: tb/tad_deilv_tb.sv
module tad_deilv_tb;
  localparam int AW = 46;
  localparam logic [63:0] AMASK = (64'd1 << AW) - 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [1:0] cfgKind = '0;
  logic [2:0] cfgEntry = '0;
  logic [1:0] cfgChan = '0;
  logic [31:0] cfgData = '0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic [1:0] inChan = '0;
  logic inReady, outValid, outErr;
  logic [AW-1:0] outAddr;
  logic [3:0] outSktWays;
  logic [2:0] outChWays;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tad_deilv u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgKind(cfgKind),
    .cfgEntry(cfgEntry), .cfgChan(cfgChan), .cfgData(cfgData),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inChan(inChan),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr),
    .outErr(outErr), .outSktWays(outSktWays), .outChWays(outChWays)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int granOf(input int code);
    case (code)
      0: return 6;
      1: return 8;
      2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic logic [63:0] lvlRef(input logic [63:0] v, input int g,
                                         input logic [63:0] w, input logic [63:0] low);
    logic [63:0] m;
    m = (64'd1 << g) - 1;
    return ((((v >> g) / w) << g) | (low & m)) & AMASK;
  endfunction

  function automatic logic [63:0] refAddr(input logic [63:0] a, input int sgc,
      input int cgc, input int swc, input int cwc, input logic [63:0] offFld);
    logic [63:0] ca, t, sw, cw;
    int sb, cb;
    sb = granOf(sgc); cb = granOf(cgc);
    sw = 64'd1 << swc; cw = 64'(cwc + 1);
    ca = (a - (offFld << 26)) & AMASK;
    if (cw == 3 && sb > cb) begin
      t = lvlRef(ca, cb, cw, ca);
      return lvlRef(t, sb, sw, t);
    end
    t = lvlRef(ca, sb, sw, a);
    return lvlRef(t, cb, cw, a);
  endfunction

  task automatic cfgWrite(input int kind, input int ent, input int ch,
                          input logic [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgKind = 2'(kind); cfgEntry = 3'(ent);
    cfgChan = 2'(ch); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runReq(input logic [AW-1:0] a, input int ch, input bit extra,
                        output logic [AW-1:0] ra, output logic re,
                        output logic [3:0] rsw, output logic [2:0] rcw,
                        output int lat);
    @(negedge clk);
    inAddr = a; inChan = 2'(ch); inValid = 1'b1;
    @(posedge clk);
    #1 inValid = 1'b0;
    lat = 0;
    for (int k = 0; k < 400; k++) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (outValid) break;
      if (extra && k == 0) chk(inReady == 1'b0, "R8 busy inReady", 64'(inReady), 0);
    end
    ra = outAddr; re = outErr; rsw = outSktWays; rcw = outChWays;
    if (extra) begin
      @(posedge clk);
      @(negedge clk);
      chk(outValid && outAddr == ra && outErr == re, "R8 hold",
          64'(outAddr), 64'(ra));
    end
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] ra, a;
    logic re;
    logic [3:0] rsw;
    logic [2:0] rcw;
    int lat;
    logic [63:0] e, h;
    logic [63:0] offs [4];
    offs[0] = 64'h4; offs[1] = 64'h8; offs[2] = 64'h0; offs[3] = 64'hC;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(inReady == 1'b1 && outValid == 1'b0, "R8 reset state",
        {62'd0, inReady, outValid}, 64'h2);

    // entry 0: [0, 2^28), pass-through; entry 1 overlaps: [0, 2^29)
    cfgWrite(0, 0, 0, 32'h0);
    cfgWrite(1, 0, 0, (32'h3 << 12));
    cfgWrite(0, 1, 0, (32'h2 << 6) | (32'h1 << 4));
    cfgWrite(1, 1, 0, (32'h7 << 12) | (32'h1 << 10) | (32'h3 << 8));
    // entry 2: sweep entry [2^30, 2^42)
    for (int c = 0; c < 4; c++) cfgWrite(2, 2, c, 32'(offs[c] << 4));
    for (int en = 3; en < 8; en++) begin
      cfgWrite(0, en, 0, 32'hFFFFF << 12);
      cfgWrite(1, en, 0, 32'h0);
    end

    // R1 priority: low address hits entry 0 (ways 1/1) and passes through; R9 latency
    runReq(46'h1234, 1, 1'b1, ra, re, rsw, rcw, lat);
    chk(ra == 46'h1234 && !re, "R1 entry0 addr", 64'(ra), 64'h1234);
    chk(rsw == 4'd1 && rcw == 3'd1, "R1 R3 entry0 ways", {rsw, rcw}, {4'd1, 3'd1});
    chk(lat == 3, "R9 fast latency", 64'(lat), 3);

    // R10: kind 3 write ignored
    cfgWrite(3, 0, 0, 32'hFFFF_FFFF);
    runReq(46'h1234, 1, 1'b0, ra, re, rsw, rcw, lat);
    chk(ra == 46'h1234 && rsw == 4'd1 && rcw == 3'd1 && !re, "R10 kind3 ignored",
        64'(ra), 64'h1234);

    // R1: above entry 0 limit falls to entry 1
    a = 46'h1800_0ABC;
    e = refAddr(64'(a), 1, 2, 1, 3, 0);
    runReq(a, 0, 1'b0, ra, re, rsw, rcw, lat);
    chk(ra == e[AW-1:0] && !re, "R1 R4 entry1 addr", 64'(ra), e);
    chk(rsw == 4'd2 && rcw == 3'd4, "R1 R3 entry1 ways", {rsw, rcw}, {4'd2, 3'd4});

    // R2: gap between entry 1 and 2, and far above all limits
    runReq(46'h3FFF_FFFF, 0, 1'b0, ra, re, rsw, rcw, lat);
    chk(re && ra == 0 && rsw == 0 && rcw == 0, "R2 gap miss", {re, 63'(ra)}, 64'h8000_0000_0000_0000);
    chk(lat == 1, "R9 miss latency", 64'(lat), 1);
    runReq(46'h1000_0000_0000, 3, 1'b0, ra, re, rsw, rcw, lat);
    chk(re && ra == 0, "R2 high miss", {re, 63'(ra)}, 64'h8000_0000_0000_0000);

    // R1 bounds of entry 2, inclusive
    cfgWrite(0, 2, 0, (32'h10 << 12));
    cfgWrite(1, 2, 0, (32'hFFFF << 12));
    runReq(46'h4000_0000, 2, 1'b0, ra, re, rsw, rcw, lat);
    chk(!re && ra == 46'h4000_0000, "R1 base inclusive", 64'(ra), 64'h4000_0000);
    runReq(46'h3FF_FFFF_FFFF, 2, 1'b0, ra, re, rsw, rcw, lat);
    chk(!re && ra == 46'h3FF_FFFF_FFFF, "R1 limit inclusive", 64'(ra), 64'h3FF_FFFF_FFFF);
    runReq(46'h400_0000_0000, 2, 1'b0, ra, re, rsw, rcw, lat);
    chk(re, "R2 limit plus one", 64'(re), 1);

    // sweep of every granularity and way combination
    for (int sg = 0; sg < 4; sg++)
      for (int cg = 0; cg < 4; cg++)
        for (int sw = 0; sw < 4; sw++)
          for (int cw = 0; cw < 4; cw++) begin
            cfgWrite(0, 2, 0, (32'h10 << 12) | 32'(cg << 6) | 32'(sg << 4));
            cfgWrite(1, 2, 0, (32'hFFFF << 12) | 32'(sw << 10) | 32'(cw << 8));
            for (int k = 0; k < 2; k++) begin
              int ch;
              ch = (sg + cg + sw + cw + k) % 4;
              h = 64'(((sg * 64 + cg * 16 + sw * 4 + cw) * 2 + k + 1)) * 64'h9E37_79B9_7F4A_7C15;
              a = AW'((64'd1 << 30) + ((h >> 7) & ((64'd1 << 41) - 1)));
              e = refAddr(64'(a), sg, cg, sw, cw, offs[ch]);
              runReq(a, ch, 1'b0, ra, re, rsw, rcw, lat);
              if (cw == 2 && granOf(sg) > granOf(cg))
                chk(!re && ra == e[AW-1:0], "R7 R5 R4 channel-first", 64'(ra), e);
              else
                chk(!re && ra == e[AW-1:0], "R6 R5 R4 socket-first", 64'(ra), e);
              chk(rsw == 4'(1 << sw) && rcw == 3'(cw + 1), "R3 ways",
                  {rsw, rcw}, {4'(1 << sw), 3'(cw + 1)});
            end
          end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule